// File: doc/BRIEF.md
# Source Operand Constant Generator

This block sits in the operand-decode stage of a 16-bit processor. It takes the source register number, the two-bit source addressing-mode field and the byte/word select of an instruction. It decides whether the source operand is an implied constant or a normal register or memory access. Two register numbers are given a second meaning. The status register (register 2) and a constant register (register 3) are combined with the mode bits so that six frequently used immediates cost no extension word in the code stream.

The block is purely combinational. When the constant path applies, it raises a valid flag and drives the constant, cut to its low byte for byte operations. It also reports whether the source needs an extension word from the instruction stream. Separately, it flags the one case where register 2 is read as the plain status register. The downstream operand mux uses these flags to choose between the constant, the register file and the memory fetch.

Top module: `srcconst_gen`

## Requirements
- R1: Register 3 with mode 00 gives a valid constant of 0x0000.
- R2: Register 3 with mode 01 gives a valid constant of 0x0001, and no extension word is requested.
- R3: Register 3 with mode 10 gives a valid constant of 0x0002.
- R4: Register 3 with mode 11 gives a valid constant of 0xFFFF.
- R5: Register 2 with mode 10 gives a valid constant of 0x0004, and register 2 with mode 11 gives 0x0008.
- R6: Register 2 with mode 00 raises `sr_as_reg` and produces no constant. Register 2 with mode 01 is absolute addressing with a zero base: it produces no constant and requests an extension word. `sr_as_reg` is low for every other input.
- R7: When `byte_op` is 1, the constant is cut to its low 8 bits, so bits 15..8 read 0. When `byte_op` is 0, the full 16-bit value is driven.
- R8: For any register number other than 2 or 3, `const_valid` is low. Whenever `const_valid` is low, `const_value` reads 0x0000.
- R9: `need_ext_word` is high exactly in two cases: mode 01 with any register other than 3, and mode 11 with register 0 (immediate from the instruction stream).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_reg | input | 4 | Source register number |
| src_mode | input | 2 | Source addressing-mode field |
| byte_op | input | 1 | 1 = byte operation, 0 = word operation |
| const_valid | output | 1 | Source operand is an implied constant |
| const_value | output | 16 | Constant value; 0 when not valid |
| need_ext_word | output | 1 | Source needs an extension word from the instruction stream |
| sr_as_reg | output | 1 | Register 2 is read as the plain status register |

## Verification
The bench sweeps every register and mode pair in both byte and word width, then applies seeded random vectors. The corners it targets are these:
- Register 2 in mode 01 must read as absolute addressing. A design that treated it as a constant would return a bogus immediate and skip the extension word.
- Register 3 in mode 01 must not fetch an extension word. Getting it wrong would misalign every following instruction.
- The all-ones constant in byte mode must come out as 0x00FF. A design without truncation would leak the high byte into byte arithmetic.
- The immediate case, register 0 in mode 11, must request an extension word and produce no constant.

// File: rtl/srcconst_gen.sv
module srcconst_gen #(
  parameter int DATA_W = 16,
  parameter int REG_W  = 4,
  parameter int PC_IDX = 0,
  parameter int SR_IDX = 2,
  parameter int CG_IDX = 3
) (
  input  logic [REG_W-1:0]  src_reg,
  input  logic [1:0]        src_mode,
  input  logic              byte_op,
  output logic              const_valid,
  output logic [DATA_W-1:0] const_value,
  output logic              need_ext_word,
  output logic              sr_as_reg
);
  localparam int BYTE_W = 8;
  localparam logic [REG_W-1:0] R_PC = REG_W'(PC_IDX);
  localparam logic [REG_W-1:0] R_SR = REG_W'(SR_IDX);
  localparam logic [REG_W-1:0] R_CG = REG_W'(CG_IDX);

  logic is_sr, is_cg;
  logic [DATA_W-1:0] raw;

  assign is_sr = (src_reg == R_SR);
  assign is_cg = (src_reg == R_CG);

  assign sr_as_reg   = is_sr && (src_mode == 2'b00);
  assign const_valid = is_cg || (is_sr && src_mode[1]);

  always_comb begin
    raw = '0;
    if (is_cg) begin
      case (src_mode)
        2'b00:   raw = '0;
        2'b01:   raw = DATA_W'(1);
        2'b10:   raw = DATA_W'(2);
        default: raw = '1;
      endcase
    end else if (is_sr) begin
      case (src_mode)
        2'b10:   raw = DATA_W'(4);
        2'b11:   raw = DATA_W'(8);
        default: raw = '0;
      endcase
    end
  end

  assign const_value = byte_op ? {{(DATA_W-BYTE_W){1'b0}}, raw[BYTE_W-1:0]} : raw;

  assign need_ext_word = ((src_mode == 2'b01) && !is_cg) ||
                         ((src_mode == 2'b11) && (src_reg == R_PC));

  always_comb begin
    if (!$isunknown({src_reg, src_mode, byte_op})) begin
      a_r2_cg_one_no_ext: assert (!(is_cg && src_mode == 2'b01) || (const_valid && !need_ext_word))
        else $error("R2 violated");
      a_r6_sr_exclusive: assert (!(sr_as_reg && const_valid))
        else $error("R6 violated");
      a_r6_abs_needs_ext: assert (!(is_sr && src_mode == 2'b01) || (need_ext_word && !const_valid))
        else $error("R6 violated");
      a_r7_byte_high_clear: assert (!byte_op || const_value[DATA_W-1:BYTE_W] == '0)
        else $error("R7 violated");
      a_r8_idle_zero: assert (const_valid || const_value == '0)
        else $error("R8 violated");
      a_r9_const_no_ext: assert (!(const_valid && need_ext_word))
        else $error("R9 violated");
    end
  end
endmodule

// File: tb/srcconst_gen_tb_top.sv
module srcconst_gen_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  src_reg;
  logic [1:0]  src_mode;
  logic        byte_op;
  logic        const_valid;
  logic [15:0] const_value;
  logic        need_ext_word;
  logic        sr_as_reg;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  srcconst_gen dut_i (
    .src_reg(src_reg), .src_mode(src_mode), .byte_op(byte_op),
    .const_valid(const_valid), .const_value(const_value),
    .need_ext_word(need_ext_word), .sr_as_reg(sr_as_reg)
  );

  function automatic logic exp_valid(logic [3:0] r, logic [1:0] m);
    return (r == 4'd3) || (r == 4'd2 && m[1]);
  endfunction

  function automatic logic [15:0] exp_value(logic [3:0] r, logic [1:0] m, logic b);
    logic [15:0] v;
    v = 16'h0000;
    if (r == 4'd3) v = (m == 2'b00) ? 16'h0000 : (m == 2'b01) ? 16'h0001 :
                       (m == 2'b10) ? 16'h0002 : 16'hFFFF;
    else if (r == 4'd2 && m == 2'b10) v = 16'h0004;
    else if (r == 4'd2 && m == 2'b11) v = 16'h0008;
    if (b) v = v & 16'h00FF;
    return v;
  endfunction

  function automatic logic exp_ext(logic [3:0] r, logic [1:0] m);
    return (m == 2'b01 && r != 4'd3) || (m == 2'b11 && r == 4'd0);
  endfunction

  function automatic string tag_of(logic [3:0] r, logic [1:0] m, logic b);
    if (r == 4'd3 && b) return "R7";
    if (r == 4'd3) case (m) 2'b00: return "R1"; 2'b01: return "R2";
                            2'b10: return "R3"; default: return "R4"; endcase
    if (r == 4'd2) return (m[1]) ? "R5" : "R6";
    if (exp_ext(r, m)) return "R9";
    return "R8";
  endfunction

  task automatic apply(input logic [3:0] r, input logic [1:0] m, input logic b);
    logic       ev, ex, es;
    logic [15:0] ed;
    string t;
    @(negedge clk);
    src_reg = r; src_mode = m; byte_op = b;
    @(posedge clk); #2;
    ev = exp_valid(r, m); ed = exp_value(r, m, b);
    ex = exp_ext(r, m); es = (r == 4'd2 && m == 2'b00);
    t = tag_of(r, m, b);
    n_vec++;
    if (const_valid !== ev || const_value !== ed || need_ext_word !== ex || sr_as_reg !== es) begin
      n_bad++;
      $display("FAIL %s reg=%0d mode=%0d byte=%0b got v=%0b d=%h x=%0b s=%0b exp v=%0b d=%h x=%0b s=%0b",
               t, r, m, b, const_valid, const_value, need_ext_word, sr_as_reg, ev, ed, ex, es);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    src_reg = '0; src_mode = '0; byte_op = 1'b0;
    seed = 32'd1234;
    void'($urandom(seed));
    // directed corners: R4 all-ones word, R7 byte cut, R6 absolute, R2 no ext, R9 immediate
    apply(4'd3, 2'b11, 1'b0);
    apply(4'd3, 2'b11, 1'b1);
    apply(4'd2, 2'b01, 1'b0);
    apply(4'd2, 2'b00, 1'b1);
    apply(4'd3, 2'b01, 1'b0);
    apply(4'd0, 2'b11, 1'b0);
    apply(4'd2, 2'b11, 1'b1);
    // exhaustive sweep covers R1..R9
    for (int r = 0; r < 16; r++)
      for (int m = 0; m < 4; m++)
        for (int b = 0; b < 2; b++)
          apply(4'(r), 2'(m), 1'(b));
    for (int i = 0; i < 300; i++)
      apply(4'($urandom), 2'($urandom), 1'($urandom));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule